// File: doc/BRIEF.md
# Serial Bit Clock Generator

This block produces the bit clock used by one direction of a synchronous serial port. It runs entirely in the system clock domain. The clock it derives is carried as a level that changes on system clock edges, plus a single-cycle enable pulse, `bit_tick`, on the active edge. The shifting logic downstream uses that pulse as a clock enable. The block can also drive the derived clock onto an output pin.

The clock comes from one of three sources. The first is an internal divider of the system clock. The second is the clock of the opposite direction. The third is an external clock pin. The two outside clocks pass through a two-flop synchronizer first. An inversion bit chooses which edge of the selected clock is the active one. A gating field can let the clock through only while the frame sync is at a chosen level. The pin stage can leave the pin as an input, drive the clock all the time, or drive it only while a transfer is in progress. When it drives only during transfers, it holds the pin low between transfers.

Top module: `bclk_gen`

## Requirements
- R1: While `rst_n` is low, `bit_tick`, `pin_clk` and `pin_oe` are all 0.
- R2: With source code 0 and a divider value N greater than 0, the divided clock has a period of 2*N system cycles: N cycles low, then N cycles high. `bit_tick` pulses once per period.
- R3: With source code 0 and a divider value of 0, the divided clock is held low and `bit_tick` never pulses.
- R4: With source code 1, the clock is `opp_clk` passed through two synchronizer flops. A rising edge of `opp_clk` set up before system clock edge k raises `bit_tick` on edge k+2 (non-inverted, ungated).
- R5: With source code 2, the clock is `ext_clk`, with the same synchronization and latency as R4. Source code 3 selects a constant low level, and `bit_tick` never pulses.
- R6: With `cfg_inv` at 1, the selected clock is inverted. The active edge becomes the falling edge of the source, and the pin drives the inverted level.
- R7: Gating code 1 passes the clock only while `fsync` is 0. Gating code 2 passes it only while `fsync` is 1. Codes 0 and 3 pass it always. A blocked cycle gives no `bit_tick` and a low clock level at the pin stage.
- R8: Output mode 0 makes `pin_oe` 0 and `pin_clk` 0. Output mode 1 makes `pin_oe` 1 and drives the gated clock level on `pin_clk`, one cycle late. Modes 3 to 7 behave as mode 0.
- R9: Output mode 2 keeps `pin_oe` at 1. It drives the gated clock level on `pin_clk` only in cycles where `xfer_active` is 1, and 0 in other cycles.
- R10: `bit_tick` is never high on two consecutive cycles.
- R11: In the first cycle after reset release, `bit_tick` stays 0 even if the inverted clock level is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 12 | Divider value N (0 stops the divided clock) |
| cfg_src | input | 2 | Clock source: 0 divided, 1 opposite direction, 2 external pin |
| cfg_out | input | 3 | Pin mode: 0 input, 1 continuous, 2 only during transfer |
| cfg_inv | input | 1 | Invert the selected clock |
| cfg_gate | input | 2 | Gating: 0 none, 1 while fsync low, 2 while fsync high |
| ext_clk | input | 1 | External clock pin (asynchronous) |
| opp_clk | input | 1 | Opposite direction clock (asynchronous) |
| fsync | input | 1 | Frame sync level, synchronous to clk |
| xfer_active | input | 1 | A data transfer is in progress |
| bit_tick | output | 1 | Single-cycle enable on the active clock edge |
| pin_clk | output | 1 | Clock value driven to the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
Some properties are checked by assertions on every cycle:
- the divider counter stays below its limit;
- no tick appears in a cycle blocked by the gate level;
- ticks never fall on consecutive cycles;
- no tick appears in the first cycle after reset;
- the pin is released in the input modes;
- in transfer-only mode the pin is driven low between transfers.

Other behaviour is shown only by the bench's scenarios, which compare every cycle against a behavioural model:
- the exact 2*N period;
- the two-edge synchronizer latency of the outside clocks;
- the swap of the active edge under inversion;
- the correct tick counts for each source.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  typedef enum logic [1:0] {
    SRC_DIV = 2'd0,
    SRC_OPP = 2'd1,
    SRC_EXT = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    OUT_NONE = 3'd0,
    OUT_CONT = 3'd1,
    OUT_XFER = 3'd2
  } out_e;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_LOW  = 2'd1,
    GATE_HIGH = 2'd2
  } gate_e;
endpackage

// File: rtl/bclk_div.sv
module bclk_div #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             lvl
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (div == '0) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (cnt_q >= div - 1'b1) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div != '0 && $stable(div)) |-> (cnt_q < div));

  // R3
  div_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> !lvl_q);
endmodule

// File: rtl/bclk_sync.sv
module bclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[i] <= 1'b0;
        else        sh_q[i] <= sh_q[i-1];
      end
    end
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/bclk_pin.sv
module bclk_pin
  import bclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       lvl,
  input  logic       xfer,
  output logic       pin,
  output logic       oe
);
  logic pin_d, oe_d, pin_q, oe_q;

  always_comb begin
    pin_d = 1'b0;
    oe_d  = 1'b0;
    case (out_e'(mode))
      OUT_CONT: begin
        oe_d  = 1'b1;
        pin_d = lvl;
      end
      OUT_XFER: begin
        oe_d  = 1'b1;
        pin_d = xfer & lvl;
      end
      default: begin
        oe_d  = 1'b0;
        pin_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      pin_q <= pin_d;
      oe_q  <= oe_d;
    end
  end

  assign pin = pin_q;
  assign oe  = oe_q;

  // R8
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode > 3'd2) |=> (!oe && !pin));

  // R9
  xfer_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !xfer) |=> (oe && !pin));
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_src,
  input  logic [2:0]       cfg_out,
  input  logic             cfg_inv,
  input  logic [1:0]       cfg_gate,
  input  logic             ext_clk,
  input  logic             opp_clk,
  input  logic             fsync,
  input  logic             xfer_active,
  output logic             bit_tick,
  output logic             pin_clk,
  output logic             pin_oe
);
  logic div_lvl, opp_lvl, ext_lvl;
  logic sel_lvl, pol_lvl, gate_ok, gated_lvl;
  logic pol_q, primed_q, tick_q, tick_d;

  bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .lvl(div_lvl)
  );

  bclk_sync #(.STAGES(SYNC_STAGES)) u_sync_opp (
    .clk(clk), .rst_n(rst_n), .din(opp_clk), .dout(opp_lvl)
  );

  bclk_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
    .clk(clk), .rst_n(rst_n), .din(ext_clk), .dout(ext_lvl)
  );

  always_comb begin
    case (src_e'(cfg_src))
      SRC_DIV: sel_lvl = div_lvl;
      SRC_OPP: sel_lvl = opp_lvl;
      SRC_EXT: sel_lvl = ext_lvl;
      default: sel_lvl = 1'b0;
    endcase
    pol_lvl = sel_lvl ^ cfg_inv;
    case (gate_e'(cfg_gate))
      GATE_LOW:  gate_ok = ~fsync;
      GATE_HIGH: gate_ok = fsync;
      default:   gate_ok = 1'b1;
    endcase
    gated_lvl = pol_lvl & gate_ok;
    tick_d    = pol_lvl & ~pol_q & primed_q & gate_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q    <= 1'b0;
      primed_q <= 1'b0;
      tick_q   <= 1'b0;
    end else begin
      pol_q    <= pol_lvl;
      primed_q <= 1'b1;
      tick_q   <= tick_d;
    end
  end

  bclk_pin u_pin (
    .clk(clk), .rst_n(rst_n), .mode(cfg_out), .lvl(gated_lvl),
    .xfer(xfer_active), .pin(pin_clk), .oe(pin_oe)
  );

  assign bit_tick = tick_q;

  // R10
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // R7
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate == 2'd1 && fsync) |=> !bit_tick);

  // R7
  gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate == 2'd2 && !fsync) |=> !bit_tick);

  // R11
  first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |=> !bit_tick);
endmodule

// File: tb/bclk_gen_tb.sv
`timescale 1ns/1ps
module bclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_div = '0;
  logic [1:0]  cfg_src = '0;
  logic [2:0]  cfg_out = '0;
  logic        cfg_inv = 1'b0;
  logic [1:0]  cfg_gate = '0;
  logic        ext_clk = 1'b0;
  logic        opp_clk = 1'b0;
  logic        fsync = 1'b0;
  logic        xfer_active = 1'b0;
  logic        bit_tick, pin_clk, pin_oe;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  bclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_src(cfg_src),
    .cfg_out(cfg_out), .cfg_inv(cfg_inv), .cfg_gate(cfg_gate),
    .ext_clk(ext_clk), .opp_clk(opp_clk), .fsync(fsync),
    .xfer_active(xfer_active), .bit_tick(bit_tick),
    .pin_clk(pin_clk), .pin_oe(pin_oe)
  );

  // Behavioural reference: phase counter for the divider, history queues
  // for the synchronized clocks, outputs predicted one edge ahead.
  int   ph = 0;
  bit   ext_h[$] = '{0, 0};
  bit   opp_h[$] = '{0, 0};
  bit   m_prev = 0, m_primed = 0;
  bit   e_tick = 0, e_pin = 0, e_oe = 0;

  always @(posedge clk) begin
    bit sel, pol, gok, lvl;
    int n;
    n = int'(cfg_div);
    if (!rst_n) begin
      ph = 0; ext_h = '{0, 0}; opp_h = '{0, 0};
      m_prev = 0; m_primed = 0; e_tick = 0; e_pin = 0; e_oe = 0;
    end else begin
      case (cfg_src)
        2'd0: sel = (n != 0) && (ph >= n);
        2'd1: sel = opp_h[0];
        2'd2: sel = ext_h[0];
        default: sel = 0;
      endcase
      pol = sel ^ cfg_inv;
      gok = (cfg_gate == 2'd1) ? !fsync : (cfg_gate == 2'd2) ? fsync : 1'b1;
      lvl = pol && gok;
      e_tick = pol && !m_prev && m_primed && gok;
      if (cfg_out == 3'd1) begin e_oe = 1; e_pin = lvl; end
      else if (cfg_out == 3'd2) begin e_oe = 1; e_pin = lvl && xfer_active; end
      else begin e_oe = 0; e_pin = 0; end
      m_prev = pol; m_primed = 1;
      void'(ext_h.pop_front()); ext_h.push_back(ext_clk);
      void'(opp_h.pop_front()); opp_h.push_back(opp_clk);
      if (n == 0) ph = 0; else ph = (ph + 1) % (2 * n);
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  int tick_cnt = 0;
  int back2back = 0;

  task automatic start(input int dv, input int src, input int om, input bit inv, input int gt);
    rst_n = 1'b0;
    cfg_div = 12'(dv); cfg_src = 2'(src); cfg_out = 3'(om); cfg_inv = inv; cfg_gate = 2'(gt);
    ext_clk = 0; opp_clk = 0; fsync = 0; xfer_active = 0;
    @(negedge clk);
    @(negedge clk);
    // R1
    check("R1", "tick_in_reset", int'(bit_tick), 0);
    check("R1", "pin_in_reset", int'(pin_clk), 0);
    check("R1", "oe_in_reset", int'(pin_oe), 0);
    rst_n = 1'b1;
    tick_cnt = 0;
    back2back = 0;
  endtask

  task automatic run(input string tag, input int n, input int opp_half, input int ext_half,
                     input int fs_half, input int xf_half);
    bit prev_tick;
    prev_tick = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, "bit_tick", int'(bit_tick), int'(e_tick));
      check(tag, "pin_clk", int'(pin_clk), int'(e_pin));
      check(tag, "pin_oe", int'(pin_oe), int'(e_oe));
      if (bit_tick) tick_cnt++;
      if (bit_tick && prev_tick) back2back++;
      prev_tick = bit_tick;
      if (opp_half > 0 && (i % opp_half) == opp_half - 1) opp_clk = ~opp_clk;
      if (ext_half > 0 && (i % ext_half) == ext_half - 1) ext_clk = ~ext_clk;
      if (fs_half > 0 && (i % fs_half) == fs_half - 1) fsync = ~fsync;
      if (xf_half > 0 && (i % xf_half) == xf_half - 1) xfer_active = ~xfer_active;
    end
  endtask

  function automatic int near(input int a, input int b);
    return ((a - b) <= 1 && (b - a) <= 1) ? 1 : 0;
  endfunction

  initial begin : watchdog
    #(4 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R2: divider N=3, continuous pin
    start(3, 0, 1, 0, 0);
    run("R2", 120, 0, 0, 0, 0);
    check("R2", "tick_count_div3", near(tick_cnt, 20), 1);
    // R2: divider N=1 (fastest), and a larger N
    start(1, 0, 1, 0, 0);
    run("R2", 80, 0, 0, 0, 0);
    check("R2", "tick_count_div1", near(tick_cnt, 40), 1);
    start(7, 0, 1, 0, 0);
    run("R2", 140, 0, 0, 0, 0);
    check("R2", "tick_count_div7", near(tick_cnt, 10), 1);
    // R10: never back to back at the fastest rate
    start(1, 0, 1, 0, 0);
    run("R10", 60, 0, 0, 0, 0);
    check("R10", "back_to_back_ticks", back2back, 0);
    // R3: divider 0 stops the clock
    start(0, 0, 1, 0, 0);
    run("R3", 60, 0, 0, 0, 0);
    check("R3", "tick_count_div0", tick_cnt, 0);
    // R4: opposite-direction clock
    start(5, 1, 1, 0, 0);
    run("R4", 100, 4, 3, 0, 0);
    check("R4", "tick_count_opp", near(tick_cnt, 12), 1);
    // R4: latency of one rising edge (edge k+2)
    start(0, 1, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    opp_clk = 1;
    @(negedge clk); check("R4", "latency_k", int'(bit_tick), 0);
    @(negedge clk); check("R4", "latency_k1", int'(bit_tick), 0);
    @(negedge clk); check("R4", "latency_k2", int'(bit_tick), 1);
    // R5: external clock, then constant source code 3
    start(5, 2, 1, 0, 0);
    run("R5", 100, 3, 5, 0, 0);
    check("R5", "tick_count_ext", near(tick_cnt, 10), 1);
    start(2, 3, 1, 0, 0);
    run("R5", 50, 2, 2, 0, 0);
    check("R5", "tick_count_src3", tick_cnt, 0);
    // R6 and R11: inverted divided clock, high right after reset
    start(4, 0, 1, 1, 0);
    @(negedge clk);
    check("R11", "first_cycle_tick", int'(bit_tick), 0);
    run("R6", 96, 0, 0, 0, 0);
    start(0, 2, 1, 1, 0);
    run("R6", 80, 0, 4, 0, 0);
    // R7: gating with a moving fsync, and fully blocked
    start(2, 0, 1, 0, 1);
    run("R7", 120, 0, 0, 7, 0);
    start(2, 0, 1, 0, 2);
    run("R7", 120, 0, 0, 5, 0);
    start(2, 0, 1, 0, 3);
    run("R7", 60, 0, 0, 3, 0);
    start(2, 0, 1, 0, 1);
    fsync = 1;
    run("R7", 60, 0, 0, 0, 0);
    check("R7", "blocked_tick_count", tick_cnt, 0);
    // R8: pin modes 0 and 5 release the pin
    start(2, 0, 0, 0, 0);
    run("R8", 40, 0, 0, 0, 0);
    start(2, 0, 5, 0, 0);
    run("R8", 40, 0, 0, 0, 0);
    check("R8", "oe_mode5", int'(pin_oe), 0);
    // R9: transfer-only pin drive
    start(2, 0, 2, 0, 0);
    run("R9", 150, 0, 0, 0, 11);
    start(3, 0, 2, 1, 2);
    run("R9", 150, 0, 0, 9, 13);
    check("R9", "oe_xfer_mode", int'(pin_oe), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule